// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an adder/subtractor and derives the six arithmetic status flags for the operation that just ran. It takes the two operands, the operation kind (add or subtract), an operand-size select (8, 16 or 32 bits) and the result the adder produced. From these it forms carry, parity, half-carry, zero, sign and overflow. Only the active width takes part; operand and result bits above it are ignored.

The flags appear combinationally on `flags_now`. An optional status register, chosen by a parameter, copies `flags_now` into `flags_q` on a clock edge when `upd` is high. It holds its value otherwise. Both flag vectors share one layout: bit 0 carry, bit 1 parity, bit 2 half-carry, bit 3 zero, bit 4 sign, bit 5 overflow.

Top module: `arith_flag_unit`

## Requirements
- R1: Bit 0 (carry) is 1 when the top bit of the active width carries out on an add (`op_sub`=0) or borrows on a subtract (`op_sub`=1), and 0 otherwise.
- R2: Bit 1 (parity) is 1 when the low 8 bits of `res` hold an even number of ones and 0 when they hold an odd number, for every size.
- R3: Bit 2 (half-carry) is 1 on a carry or borrow across a boundary that depends on size. For the 8-bit and 32-bit sizes the boundary is from bit 3 into bit 4. For the 16-bit size it is from bit 7 into bit 8.
- R4: Bit 3 (zero) is 1 exactly when `res` is zero within the active width.
- R5: Bit 4 (sign) equals the top bit of `res` within the active width.
- R6: Bit 5 (overflow) is 1 when the true signed two's-complement result does not fit in the active width. On an add this is when the operands share a sign and the result sign differs. On a subtract it is when the operand signs differ and the result sign differs from `opa`.
- R7: `size_sel` 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits. Bits of `opa`, `opb` and `res` above the active width do not change any flag.
- R8: With the register present, `flags_q` is 0 while `rst_n` is low. It takes the value `flags_now` had before a rising edge at which `upd` is 1, and it keeps its value across an edge at which `upd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low synchronous reset of the status register |
| op_sub | input | 1 | 0 = add, 1 = subtract (`res` = `opa` - `opb`) |
| size_sel | input | 2 | Operand size: 00 byte, 01 16-bit, 1x 32-bit |
| opa | input | DATA_W | First operand (minuend on subtract) |
| opb | input | DATA_W | Second operand (subtrahend on subtract) |
| res | input | DATA_W | Result produced by the adder |
| upd | input | 1 | Load strobe for the status register |
| flags_now | output | 6 | Combinational flags {of,sf,zf,af,pf,cf} |
| flags_q | output | 6 | Registered flags, same layout |

## Verification
A wrong tap in the bit-selection logic shows up at once on `flags_now`, in the same cycle the operands are applied. Picking the wrong top bit or boundary bit corrupts carry, sign, overflow or half-carry only at certain sizes. For that reason every size is driven with operands placed right at the carry, borrow and signed-range boundaries. A masking fault that lets upper bits leak in is caught by rerunning the same operations with junk above the active width and expecting identical flags. A fault in the status register appears one edge after a strobe or a skipped strobe, and the bench compares `flags_q` at the next falling edge.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_DWALT = 2'b11
    } size_e;

    // packed so that a cast to 6 bits gives {of,sf,zf,af,pf,cf}
    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } flags_t;

    localparam int FLAG_W = 6;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

endpackage

// File: rtl/flag_operand_slice.sv
module flag_operand_slice
    import arith_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] res,
    output logic              a_top,
    output logic              b_top,
    output logic              r_top,
    output logic              a_half,
    output logic              b_half,
    output logic              r_half,
    output logic [DATA_W-1:0] res_masked
);
    localparam int NIB_POS  = 4;
    localparam int BYTE_POS = BYTE_W;

    logic [DATA_W-1:0] mask;

    always_comb begin
        unique case (size_e'(size_sel))
            SZ_BYTE: begin
                mask  = DATA_W'((64'd1 << BYTE_W) - 64'd1);
                a_top = opa[BYTE_W-1];
                b_top = opb[BYTE_W-1];
                r_top = res[BYTE_W-1];
            end
            SZ_WORD: begin
                mask  = DATA_W'((64'd1 << WORD_W) - 64'd1);
                a_top = opa[WORD_W-1];
                b_top = opb[WORD_W-1];
                r_top = res[WORD_W-1];
            end
            default: begin
                mask  = '1;
                a_top = opa[DATA_W-1];
                b_top = opb[DATA_W-1];
                r_top = res[DATA_W-1];
            end
        endcase
        res_masked = res & mask;
    end

    // half-carry boundary: byte boundary for 16-bit, nibble otherwise
    always_comb begin
        if (size_e'(size_sel) == SZ_WORD) begin
            a_half = opa[BYTE_POS];
            b_half = opb[BYTE_POS];
            r_half = res[BYTE_POS];
        end else begin
            a_half = opa[NIB_POS];
            b_half = opb[NIB_POS];
            r_half = res[NIB_POS];
        end
    end

endmodule

// File: rtl/flag_carry_unit.sv
module flag_carry_unit (
    input  logic op_sub,
    input  logic a_top,
    input  logic b_top,
    input  logic r_top,
    input  logic a_half,
    input  logic b_half,
    input  logic r_half,
    output logic cf,
    output logic af,
    output logic of
);
    logic carry_out;
    logic borrow_out;

    always_comb begin
        // carry/borrow out of the top bit, rebuilt from operand and result bits
        carry_out  = (a_top & b_top) | ((a_top | b_top) & ~r_top);
        borrow_out = (~a_top & b_top) | ((~a_top | b_top) & r_top);
        cf         = op_sub ? borrow_out : carry_out;
        // carry or borrow into a bit equals the xor of the three bits there
        af         = a_half ^ b_half ^ r_half;
        if (op_sub)
            of = (a_top ^ b_top) & (r_top ^ a_top);
        else
            of = ~(a_top ^ b_top) & (r_top ^ a_top);
    end

endmodule

// File: rtl/flag_parity_unit.sv
module flag_parity_unit #(
    parameter int PAR_W = 8
) (
    input  logic [PAR_W-1:0] bits,
    output logic             pf
);
    logic [PAR_W:0] chain;

    assign chain[0] = 1'b1;
    generate
        for (genvar i = 0; i < PAR_W; i++) begin : g_chain
            assign chain[i+1] = chain[i] ^ bits[i];
        end
    endgenerate

    assign pf = chain[PAR_W];

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import arith_flag_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit HAS_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_sub,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] res,
    input  logic              upd,
    output logic [5:0]        flags_now,
    output logic [5:0]        flags_q
);
    logic              a_top, b_top, r_top;
    logic              a_half, b_half, r_half;
    logic [DATA_W-1:0] res_masked;
    logic              cf_w, af_w, of_w, pf_w;
    flags_t            flags_d;

    flag_operand_slice #(.DATA_W(DATA_W)) u_slice (
        .size_sel   (size_sel),
        .opa        (opa),
        .opb        (opb),
        .res        (res),
        .a_top      (a_top),
        .b_top      (b_top),
        .r_top      (r_top),
        .a_half     (a_half),
        .b_half     (b_half),
        .r_half     (r_half),
        .res_masked (res_masked)
    );

    flag_carry_unit u_carry (
        .op_sub (op_sub),
        .a_top  (a_top),
        .b_top  (b_top),
        .r_top  (r_top),
        .a_half (a_half),
        .b_half (b_half),
        .r_half (r_half),
        .cf     (cf_w),
        .af     (af_w),
        .of     (of_w)
    );

    flag_parity_unit #(.PAR_W(BYTE_W)) u_par (
        .bits (res[BYTE_W-1:0]),
        .pf   (pf_w)
    );

    always_comb begin
        flags_d.cf_f = cf_w;
        flags_d.pf_f = pf_w;
        flags_d.af_f = af_w;
        flags_d.zf_f = (res_masked == '0);
        flags_d.sf_f = r_top;
        flags_d.of_f = of_w;
    end

    assign flags_now = flags_d;

    generate
        if (HAS_REG) begin : g_reg
            flags_t status_d, status_q;

            always_comb begin
                status_d = status_q;
                if (upd)
                    status_d = flags_d;
            end

            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q <= '0;
                else
                    status_q <= status_d;
            end

            assign flags_q = status_q;

            // R8
            load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                upd |=> flags_q == $past(flags_now));
            // R8
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !upd |=> $stable(flags_q));
        end else begin : g_noreg
            assign flags_q = flags_now;
        end
    endgenerate

    // R4
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[3] |-> res[BYTE_W-1:0] == '0);
    // R5
    sign_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel == 2'b00) |-> flags_now[4] == res[BYTE_W-1]);
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_sub && size_sel == 2'b00 && opa[BYTE_W-1] != opb[BYTE_W-1]) |-> !flags_now[5]);
    // R2
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[1] == !($countones(res[BYTE_W-1:0]) % 2));

endmodule

// File: tb/sim_arith_flag_unit.sv
module sim_arith_flag_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_sub = 1'b0;
    logic [1:0]   size_sel = 2'b00;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] res = '0;
    logic         upd = 1'b0;
    logic [5:0]   flags_now;
    logic [5:0]   flags_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    arith_flag_unit #(.DATA_W(W), .HAS_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .size_sel(size_sel),
        .opa(opa), .opb(opb), .res(res), .upd(upd),
        .flags_now(flags_now), .flags_q(flags_q)
    );

    function automatic int width_of(input logic [1:0] sz);
        return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    endfunction

    function automatic logic [63:0] mask_of(input logic [1:0] sz);
        return (64'd1 << width_of(sz)) - 64'd1;
    endfunction

    function automatic logic [W-1:0] calc_res(input logic sub, input logic [1:0] sz,
                                              input logic [W-1:0] a, input logic [W-1:0] b);
        logic [63:0] r;
        r = sub ? ({32'd0, a} - {32'd0, b}) : ({32'd0, a} + {32'd0, b});
        return W'(r & mask_of(sz));
    endfunction

    // reference flags {of,sf,zf,af,pf,cf} from arithmetic, not from gate equations
    function automatic logic [5:0] ref_flags(input logic sub, input logic [1:0] sz,
                                             input logic [W-1:0] a, input logic [W-1:0] b);
        int          w;
        logic [63:0] m, am, bm, full, hm;
        longint      sa, sb, sr, lo, hi;
        logic        cf, pf, af, zf, sf, ovf;
        w    = width_of(sz);
        m    = mask_of(sz);
        am   = {32'd0, a} & m;
        bm   = {32'd0, b} & m;
        full = sub ? (am - bm) : (am + bm);
        cf   = sub ? (am < bm) : full[w];
        hm   = (sz == 2'b01) ? 64'hFF : 64'hF;
        af   = sub ? ((am & hm) < (bm & hm)) : (((am & hm) + (bm & hm)) > hm);
        zf   = ((full & m) == 0);
        sf   = full[w-1];
        pf   = ($countones(full[7:0]) % 2) == 0;
        sa   = am[w-1] ? longint'(am) - (longint'(1) << w) : longint'(am);
        sb   = bm[w-1] ? longint'(bm) - (longint'(1) << w) : longint'(bm);
        sr   = sub ? sa - sb : sa + sb;
        lo   = -(longint'(1) << (w-1));
        hi   = (longint'(1) << (w-1)) - 1;
        ovf  = (sr < lo) || (sr > hi);
        return {ovf, sf, zf, af, pf, cf};
    endfunction

    task automatic check6(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // apply one op with optional junk above the active width, compare at once
    task automatic run_op(input string tag, input logic sub, input logic [1:0] sz,
                          input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] junk);
        logic [W-1:0] hm;
        @(negedge clk);
        hm       = ~W'(mask_of(sz));
        op_sub   = sub;
        size_sel = sz;
        opa      = a | (junk & hm);
        opb      = b | (~junk & hm);
        res      = calc_res(sub, sz, a, b) | ((junk ^ 32'h5A5A5A5A) & hm);
        #1;
        check6(tag, flags_now, ref_flags(sub, sz, a, b));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check6("R8 reset clears flags_q", flags_q, 6'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_byte();
        run_op("R1 R6 byte add 7F+01", 1'b0, 2'b00, 32'h7F, 32'h01, '0);
        run_op("R1 R4 byte add FF+01", 1'b0, 2'b00, 32'hFF, 32'h01, '0);
        run_op("R1 R3 byte sub 10-01", 1'b1, 2'b00, 32'h10, 32'h01, '0);
        run_op("R6 byte sub 80-01",    1'b1, 2'b00, 32'h80, 32'h01, '0);
        run_op("R1 byte sub 00-01",    1'b1, 2'b00, 32'h00, 32'h01, '0);
        run_op("R2 R5 byte add 03+00", 1'b0, 2'b00, 32'h03, 32'h00, '0);
    endtask

    task automatic t_word();
        run_op("R3 word add 00FF+0001",  1'b0, 2'b01, 32'h00FF, 32'h0001, '0);
        run_op("R3 word add 000F+0001",  1'b0, 2'b01, 32'h000F, 32'h0001, '0);
        run_op("R6 word add 7FFF+0001",  1'b0, 2'b01, 32'h7FFF, 32'h0001, '0);
        run_op("R1 R4 word sub 1234-1234", 1'b1, 2'b01, 32'h1234, 32'h1234, '0);
        run_op("R3 word sub 0100-0001",  1'b1, 2'b01, 32'h0100, 32'h0001, '0);
    endtask

    task automatic t_dword();
        run_op("R1 R4 dword add FFFFFFFF+1", 1'b0, 2'b10, 32'hFFFFFFFF, 32'h1, '0);
        run_op("R6 dword sub 80000000-1",    1'b1, 2'b10, 32'h80000000, 32'h1, '0);
        run_op("R3 dword add 0000000F+1",    1'b0, 2'b11, 32'h0000000F, 32'h1, '0);
        run_op("R5 R6 dword add 7FFFFFFF+7FFFFFFF", 1'b0, 2'b11, 32'h7FFFFFFF, 32'h7FFFFFFF, '0);
        run_op("R2 dword add 000000FE+1",    1'b0, 2'b10, 32'hFE, 32'h1, '0);
    endtask

    task automatic t_upper();
        run_op("R7 byte add 7F+01 junk", 1'b0, 2'b00, 32'h7F, 32'h01, 32'hFFFFFFFF);
        run_op("R7 byte sub 00-00 junk", 1'b1, 2'b00, 32'h00, 32'h00, 32'hA5A5A5A5);
        run_op("R7 word add FFFF+1 junk", 1'b0, 2'b01, 32'hFFFF, 32'h1, 32'h12345678);
        run_op("R7 word sub 8000-1 junk", 1'b1, 2'b01, 32'h8000, 32'h1, 32'hFFFF0000);
    endtask

    task automatic t_register();
        logic [5:0] kept;
        @(negedge clk);
        op_sub = 1'b0; size_sel = 2'b00; opa = 32'h7F; opb = 32'h01;
        res = calc_res(1'b0, 2'b00, 32'h7F, 32'h01);
        upd = 1'b1;
        kept = ref_flags(1'b0, 2'b00, 32'h7F, 32'h01);
        @(negedge clk);
        upd = 1'b0;
        check6("R8 load on strobe", flags_q, kept);
        opa = 32'h00; opb = 32'h00; res = 32'h0;
        @(negedge clk);
        check6("R8 hold without strobe", flags_q, kept);
        @(negedge clk);
        check6("R8 hold second edge", flags_q, kept);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        check6("R8 reload on strobe", flags_q, ref_flags(1'b0, 2'b00, 32'h0, 32'h0));
    endtask

    initial begin
        t_reset();
        t_byte();
        t_word();
        t_dword();
        t_upper();
        t_register();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule